// File: doc/BRIEF.md
# Asynchronous SRAM Pin Test Sequencer

This block is a synchronous controller that tests an external asynchronous static RAM through the RAM's own pins. The RAM has an 11-bit address, an 8-bit data bus and three active-low controls: chip select, output enable and write strobe. After a start pulse the controller runs a fixed script of bus operations and then reports pass or fail. Each operation steps through five timed phases on the pins. Reads are sampled and compared inside the block. The first mismatch stops the run. The block records where the mismatch happened, the byte it expected and the byte it saw.

The script runs five test groups in a fixed order. The first is a pattern group: it writes twelve thermometer-coded addresses with thermometer-like data and then reads them back. The second proves that a write attempted with chip select inactive leaves the memory unchanged. The third proves that data driven while the write strobe stays high is not stored. The fourth proves that the bus floats, and reads as all ones through its pull-up, when output enable is inactive. The last group tests each data bit, 0 then 1, at address 0. The bidirectional bus appears as three separate ports: a data-out port, a drive-enable and a data-in port. The pad and the pull-up lie outside the block.

Top module: `sram_pin_tester`

## Requirements
- R1: During reset and on the first cycle after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, and busy and done are 0.
- R2: mem_dq_oe is never 1 while mem_oe_n is 0. Whenever mem_oe_n is 0, mem_ce_n is 0 and mem_we_n is 1.
- R3: mem_addr changes only on a cycle where all three strobes are 1, and only when they were also all 1 on the cycle before.
- R4: Every pin pattern of the strobes and the drive-enable lasts at least STEP_CYC cycles. A genuine write holds mem_ce_n and mem_we_n both low for exactly STEP_CYC cycles.
- R5: The pattern group first writes twelve locations. For step i (0 to 11), the address has its low i bits set. The data sequence is 00,01,03,07,0F,1F,3F,7F,FF,FE,FC,F8 (hex). The twelve locations are then read back in the same order, with a full-byte compare. Failure code 0.
- R6: The chip-select guard writes 00 to address 0. It then drives FF with mem_ce_n=1 and mem_we_n=0. It then reads address 0 and expects 00. Failure code 1.
- R7: The write-strobe guard writes FF to address 0. It then drives 00 with mem_ce_n=0 and mem_we_n=1. It then reads address 0 and expects FF. Failure code 2.
- R8: The float check writes 00 to address 0. It then samples the bus with mem_ce_n=0 and mem_oe_n=1 and expects FF. Failure code 3.
- R9: The bit group handles each bit b from 0 to 7 in turn, all at address 0. For each bit it writes 00, reads and compares bit b against 0, writes the byte with only bit b set, and reads and compares bit b against 1. Failure code 4. A genuine run performs 31 writes in total.
- R10: On the first mismatch, busy falls and done rises with pass=0, and all strobes return to 1 on that same edge. fail_phase, fail_addr, fail_expect and fail_seen hold the failure code, the address, the expected byte and the sampled byte until the next start.
- R11: A run with no mismatch holds busy for exactly 64*(5*STEP_CYC+2) cycles and then sets done=1 with pass=1.
- R12: busy rises only in response to start. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when not busy |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Run finished with no mismatch (valid with done) |
| fail_phase | output | 3 | Code of the failing test group |
| fail_addr | output | ADDR_W | Address of the failing access |
| fail_expect | output | DATA_W | Expected byte of the failing access |
| fail_seen | output | DATA_W | Byte sampled on the failing access |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | DATA_W | Byte for the bus pads |
| mem_dq_oe | output | 1 | Pad drive enable |
| mem_dq_in | input | DATA_W | Byte seen on the bus pads |

## Verification
The properties assume two things about the inputs. Reset is held for at least one edge before any start. The pad byte on mem_dq_in is a settled function of the pins the block drives, so it is read only at the end of a timed step. The bench meets both conditions. Its memory model is combinational from address and strobes, and it resolves undriven cycles to all ones, as a pull-up would. Start is driven on falling edges. Faulty behaviour is injected only through the memory model's behaviour, never through the block's own ports.

// File: rtl/sram_tst_pkg.sv
package sram_tst_pkg;

  typedef enum logic [2:0] {
    OP_WRITE    = 3'd0,
    OP_READ     = 3'd1,
    OP_CE_GHOST = 3'd2,
    OP_WE_GHOST = 3'd3,
    OP_FLOAT    = 3'd4
  } op_kind_e;

  typedef enum logic [2:0] {
    PH_PATTERN  = 3'd0,
    PH_CE_GUARD = 3'd1,
    PH_WE_GUARD = 3'd2,
    PH_OE_FLOAT = 3'd3,
    PH_BITS     = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_ARM  = 3'd2,
    ST_ACT  = 3'd3,
    ST_REL  = 3'd4,
    ST_OFF  = 3'd5
  } step_e;

  // pin pattern {ce_n, oe_n, we_n, dq_oe}
  localparam logic [3:0] PINS_IDLE = 4'b1110;

  function automatic logic [3:0] pins_for(step_e st, op_kind_e k);
    logic [3:0] p;
    p = PINS_IDLE;
    unique case (st)
      ST_ARM: begin
        if (k == OP_CE_GHOST) p = 4'b1100;
        else                  p = 4'b0110;
      end
      ST_ACT: begin
        unique case (k)
          OP_WRITE:    p = 4'b0101;
          OP_READ:     p = 4'b0010;
          OP_CE_GHOST: p = 4'b1101;
          OP_WE_GHOST: p = 4'b0111;
          default:     p = 4'b0110;
        endcase
      end
      ST_REL: begin
        unique case (k)
          OP_WRITE:    p = 4'b0111;
          OP_READ:     p = 4'b0010;
          OP_CE_GHOST: p = 4'b1111;
          OP_WE_GHOST: p = 4'b0111;
          default:     p = 4'b0110;
        endcase
      end
      default: p = PINS_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_tst_script.sv
module sram_tst_script
  import sram_tst_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int PAT_LEN = 12,
  localparam int N_OPS  = 2 * PAT_LEN + 8 + 4 * DATA_W,
  localparam int IDX_W  = $clog2(N_OPS)
) (
  input  logic [IDX_W-1:0]  idx,
  output op_kind_e          op_kind,
  output logic [2:0]        op_phase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [DATA_W-1:0] op_mask,
  output logic              op_last
);

  localparam int BASE_CE  = 2 * PAT_LEN;
  localparam int BASE_WE  = BASE_CE + 3;
  localparam int BASE_OE  = BASE_WE + 3;
  localparam int BASE_BIT = BASE_OE + 2;

  always_comb begin
    int i;
    int p;
    int j;
    int b;
    i        = int'(idx);
    p        = 0;
    j        = 0;
    b        = 0;
    op_kind  = OP_WRITE;
    op_phase = PH_PATTERN;
    op_addr  = '0;
    op_data  = '0;
    op_mask  = '1;
    if (i < BASE_CE) begin
      p = (i < PAT_LEN) ? i : i - PAT_LEN;
      op_kind = (i < PAT_LEN) ? OP_WRITE : OP_READ;
      for (int k = 0; k < ADDR_W; k++) op_addr[k] = (k < p);
      for (int k = 0; k < DATA_W; k++) op_data[k] = (k < p) && (k >= p - DATA_W);
    end else if (i < BASE_WE) begin
      op_phase = PH_CE_GUARD;
      if (i == BASE_CE + 1) begin
        op_kind = OP_CE_GHOST;
        op_data = '1;
      end else begin
        op_kind = (i == BASE_CE) ? OP_WRITE : OP_READ;
      end
    end else if (i < BASE_OE) begin
      op_phase = PH_WE_GUARD;
      if (i == BASE_WE + 1) begin
        op_kind = OP_WE_GHOST;
      end else begin
        op_kind = (i == BASE_WE) ? OP_WRITE : OP_READ;
        op_data = '1;
      end
    end else if (i < BASE_BIT) begin
      op_phase = PH_OE_FLOAT;
      op_kind  = (i == BASE_OE) ? OP_WRITE : OP_FLOAT;
      op_data  = (i == BASE_OE) ? '0 : '1;
    end else begin
      op_phase = PH_BITS;
      j = i - BASE_BIT;
      b = j / 4;
      op_kind = (j % 2 == 0) ? OP_WRITE : OP_READ;
      for (int k = 0; k < DATA_W; k++) begin
        op_data[k] = (k == b) && (j % 4 >= 2);
        op_mask[k] = (k == b) || (op_kind == OP_WRITE);
      end
    end
    op_last = (i == N_OPS - 1);
  end

endmodule

// File: rtl/sram_tst_cycle.sv
module sram_tst_cycle
  import sram_tst_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int STEP_CYC = 2,
  localparam int CNT_W   = $clog2(STEP_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              abort,
  input  op_kind_e          op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              op_done
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);

  step_e            step_q, step_d;
  logic [CNT_W-1:0] cnt_q;
  op_kind_e         kind_q, kind_sel;
  logic             step_end;
  logic             samples;

  assign step_end = (cnt_q == CNT_LAST);
  assign kind_sel = (step_q == ST_IDLE) ? op_kind : kind_q;
  assign samples  = (kind_q == OP_READ) || (kind_q == OP_FLOAT);

  always_comb begin
    step_d = step_q;
    if (abort) begin
      step_d = ST_IDLE;
    end else begin
      unique case (step_q)
        ST_IDLE: if (go) step_d = ST_ADDR;
        ST_ADDR: if (step_end) step_d = ST_ARM;
        ST_ARM:  if (step_end) step_d = ST_ACT;
        ST_ACT:  if (step_end) step_d = ST_REL;
        ST_REL:  if (step_end) step_d = ST_OFF;
        ST_OFF:  if (step_end) step_d = ST_IDLE;
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q     <= ST_IDLE;
      cnt_q      <= '0;
      kind_q     <= OP_WRITE;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} <= PINS_IDLE;
      smp_valid  <= 1'b0;
      smp_data   <= '0;
      op_done    <= 1'b0;
    end else begin
      step_q <= step_d;
      if (step_d != step_q || step_q == ST_IDLE) cnt_q <= '0;
      else                                       cnt_q <= cnt_q + 1'b1;
      if (step_q == ST_IDLE && go && !abort) begin
        kind_q     <= op_kind;
        mem_addr   <= op_addr;
        mem_dq_out <= op_data;
      end
      {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} <= pins_for(step_d, kind_sel);
      smp_valid <= 1'b0;
      if (step_q == ST_ACT && step_end && samples && !abort) begin
        smp_valid <= 1'b1;
        smp_data  <= mem_dq_in;
      end
      op_done <= (step_q == ST_OFF) && step_end && !abort;
    end
  end

endmodule

// File: rtl/sram_pin_tester.sv
module sram_pin_tester
  import sram_tst_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int PAT_LEN  = 12,
  parameter int STEP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [2:0]        fail_phase,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_expect,
  output logic [DATA_W-1:0] fail_seen,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int N_OPS = 2 * PAT_LEN + 8 + 4 * DATA_W;
  localparam int IDX_W = $clog2(N_OPS);

  logic [IDX_W-1:0]  idx_q;
  logic              run_q, go_q;
  op_kind_e          op_kind;
  logic [2:0]        op_phase;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data, op_mask;
  logic              op_last;
  logic              smp_valid, op_done;
  logic [DATA_W-1:0] smp_data;
  logic              mismatch;

  sram_tst_script #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_LEN(PAT_LEN)
  ) script_i (
    .idx(idx_q), .op_kind(op_kind), .op_phase(op_phase), .op_addr(op_addr),
    .op_data(op_data), .op_mask(op_mask), .op_last(op_last)
  );

  assign mismatch = run_q && smp_valid && (((smp_data ^ op_data) & op_mask) != '0);

  sram_tst_cycle #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_CYC(STEP_CYC)
  ) cycle_i (
    .clk(clk), .rst(rst), .go(go_q), .abort(mismatch),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .smp_valid(smp_valid), .smp_data(smp_data),
    .op_done(op_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      go_q        <= 1'b0;
      idx_q       <= '0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail_phase  <= '0;
      fail_addr   <= '0;
      fail_expect <= '0;
      fail_seen   <= '0;
    end else begin
      go_q <= 1'b0;
      if (!run_q) begin
        if (start) begin
          run_q       <= 1'b1;
          go_q        <= 1'b1;
          idx_q       <= '0;
          done        <= 1'b0;
          pass        <= 1'b0;
          fail_phase  <= '0;
          fail_addr   <= '0;
          fail_expect <= '0;
          fail_seen   <= '0;
        end
      end else if (mismatch) begin
        run_q       <= 1'b0;
        done        <= 1'b1;
        pass        <= 1'b0;
        fail_phase  <= op_phase;
        fail_addr   <= op_addr;
        fail_expect <= op_data;
        fail_seen   <= smp_data;
      end else if (op_done) begin
        if (op_last) begin
          run_q <= 1'b0;
          done  <= 1'b1;
          pass  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          go_q  <= 1'b1;
        end
      end
    end
  end

  assign busy = run_q;

endmodule

// File: rtl/sram_pin_tester_chk.sv
module sram_pin_tester_chk #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int STEP_CYC = 2,
  localparam int RUN_W   = $clog2(STEP_CYC + 1) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  localparam logic [RUN_W-1:0] RUN_MIN = RUN_W'(STEP_CYC);

  logic [3:0]       pins, pins_prev;
  logic [RUN_W-1:0] run_len;
  logic             all_high;

  assign pins     = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
  assign all_high = mem_ce_n && mem_oe_n && mem_we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_prev <= 4'b1110;
      run_len   <= RUN_MIN;
    end else begin
      pins_prev <= pins;
      if (pins != pins_prev)   run_len <= RUN_W'(1);
      else if (run_len < RUN_MIN) run_len <= run_len + 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (all_high && !mem_dq_oe && !busy && !done));

  a_r2_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r2_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  a_r3_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    (mem_addr != $past(mem_addr)) |-> (all_high && $past(all_high)));

  a_r4_step_len: assert property (@(posedge clk) disable iff (rst)
    (pins != pins_prev) |-> (run_len >= RUN_MIN));

  a_r10_fail_quiet: assert property (@(posedge clk) disable iff (rst)
    (done && !pass) |-> (all_high && !mem_dq_oe));

  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r12_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

endmodule

bind sram_pin_tester sram_pin_tester_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_CYC(STEP_CYC)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_pin_tester_tb_top.sv
module sram_pin_tester_tb_top;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int STEP = 2;
  localparam int RUN_CYC = 64 * (5 * STEP + 2);

  // expected pattern-group writes: {address, data}
  localparam logic [18:0] PAT_TAB [12] = '{
    {11'h000, 8'h00}, {11'h001, 8'h01}, {11'h003, 8'h03}, {11'h007, 8'h07},
    {11'h00F, 8'h0F}, {11'h01F, 8'h1F}, {11'h03F, 8'h3F}, {11'h07F, 8'h7F},
    {11'h0FF, 8'hFF}, {11'h1FF, 8'hFE}, {11'h3FF, 8'hFC}, {11'h7FF, 8'hF8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, pass;
  logic [2:0] fail_phase;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [DW-1:0] fail_expect, fail_seen, mem_dq_out, mem_dq_in;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

  int n_checks = 0;
  int n_fail = 0;
  int fault_mode = 0;
  logic log_clr = 1'b0;
  logic mon_en = 1'b0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  sram_pin_tester #(.ADDR_W(AW), .DATA_W(DW), .PAT_LEN(12), .STEP_CYC(STEP)) dut_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
    .fail_phase(fail_phase), .fail_addr(fail_addr), .fail_expect(fail_expect),
    .fail_seen(fail_seen), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // RAM model with pull-up; fault_mode 1..4 injects defects
  logic [DW-1:0] ram [0:2047];
  logic [AW-1:0] wr_a [0:63];
  logic [DW-1:0] wr_d [0:63];
  int   wr_count;
  logic wr_prev;
  logic wr_cond, stuck_on;

  assign wr_cond = mem_dq_oe && ((!mem_we_n && (!mem_ce_n || fault_mode == 1)) ||
                                 (fault_mode == 2 && !mem_ce_n));
  assign stuck_on = (fault_mode == 4) && (wr_count >= 15);

  always_comb begin
    if (!mem_ce_n && mem_we_n && !mem_dq_oe && (!mem_oe_n || fault_mode == 3))
      mem_dq_in = ram[mem_addr] | (stuck_on ? 8'h08 : 8'h00);
    else if (mem_dq_oe)
      mem_dq_in = mem_dq_out;
    else
      mem_dq_in = 8'hFF;
  end

  always @(posedge clk) begin
    if (wr_cond) ram[mem_addr] <= mem_dq_out;
    wr_prev <= wr_cond;
    if (log_clr) begin
      wr_count <= 0;
    end else if (wr_cond && !wr_prev && wr_count < 64) begin
      wr_a[wr_count] <= mem_addr;
      wr_d[wr_count] <= mem_dq_out;
      wr_count <= wr_count + 1;
    end
  end

  // pin monitors
  int wlen, wmin, wmax, bad_contend, bad_addr, busy_cyc;
  logic [AW-1:0] addr_prev;
  logic all_prev;
  always @(negedge clk) begin
    if (!mon_en) begin
      wlen <= 0; wmin <= 999; wmax <= 0;
      bad_contend <= 0; bad_addr <= 0; busy_cyc <= 0;
    end else begin
      if (!mem_ce_n && !mem_we_n) wlen <= wlen + 1;
      else if (wlen != 0) begin
        if (wlen < wmin) wmin <= wlen;
        if (wlen > wmax) wmax <= wlen;
        wlen <= 0;
      end
      if (mem_dq_oe && !mem_oe_n) bad_contend <= bad_contend + 1;
      if (!mem_oe_n && (mem_ce_n || !mem_we_n)) bad_contend <= bad_contend + 1;
      if (mem_addr != addr_prev && !(all_prev && mem_ce_n && mem_oe_n && mem_we_n))
        bad_addr <= bad_addr + 1;
      if (busy) busy_cyc <= busy_cyc + 1;
    end
    addr_prev <= mem_addr;
    all_prev  <= mem_ce_n && mem_oe_n && mem_we_n;
  end

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL %s: watchdog, actual done=0 expected done=1", req);
    end
  endtask

  task automatic run_fault(input int mode, input string req, input int ph,
                           input int exp_b, input int seen_b);
    fault_mode = mode;
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
    pulse_start();
    wait_done(req);
    @(negedge clk);
    check({req, " pass"}, int'(pass), 0);
    check({req, " phase"}, int'(fail_phase), ph);
    check({req, " addr"}, int'(fail_addr), 0);
    check({req, " expect"}, int'(fail_expect), exp_b);
    check({req, " seen"}, int'(fail_seen), seen_b);
    check("R10 idle pins after fail", int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}), 4'b1110);
    check("R10 busy after fail", int'(busy), 0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", int'({mem_ce_n, mem_oe_n, mem_we_n}), 3'b111);
    rst = 1'b0;
    @(negedge clk);
    check("R1 dq_oe", int'(mem_dq_oe), 0);
    check("R1 busy/done", int'({busy, done}), 0);

    // good run with a stray start while busy (R12)
    log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
    mon_en = 1'b1;
    pulse_start();
    check("R12 busy after start", int'(busy), 1);
    repeat (300) @(negedge clk);
    pulse_start();
    wait_done("R11");
    @(negedge clk);
    mon_en = 1'b0;
    check("R11 pass", int'(pass), 1);
    check("R11/R12 busy cycles", busy_cyc, RUN_CYC);
    check("R9 total writes", wr_count, 31);
    check("R2 strobe legality", bad_contend, 0);
    check("R3 address quiet", bad_addr, 0);
    check("R4 write low min", wmin, STEP);
    check("R4 write low max", wmax, STEP);

    // R5: walk expected pattern table
    for (int i = 0; i < 12; i++) begin
      check($sformatf("R5 write %0d", i), int'({wr_a[i], wr_d[i]}), int'(PAT_TAB[i]));
    end
    check("R6 setup write", int'({wr_a[12], wr_d[12]}), 0);
    check("R7 setup write", int'({wr_a[13], wr_d[13]}), 8'hFF);
    check("R8 setup write", int'({wr_a[14], wr_d[14]}), 0);
    for (int b = 0; b < 8; b++) begin
      check($sformatf("R9 bit %0d zero", b), int'({wr_a[15+2*b], wr_d[15+2*b]}), 0);
      check($sformatf("R9 bit %0d one", b), int'({wr_a[16+2*b], wr_d[16+2*b]}), 1 << b);
    end

    // defect runs
    run_fault(1, "R6", 1, 8'h00, 8'hFF);
    run_fault(2, "R7", 2, 8'hFF, 8'h00);
    run_fault(3, "R8", 3, 8'hFF, 8'h00);
    run_fault(4, "R9", 4, 8'h00, 8'h08);
    fault_mode = 0;

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule